// File: doc/BRIEF.md
# Wrap-Driven 24-bit Event Counter with Byte Window

This block keeps a 24-bit count that advances by one on each cycle in which a companion 16-bit timer reports a wrap. The count is cleared when it reaches a programmable period. Two programmable compare values each raise their own event. Every event sets a sticky flag, and a per-event mask decides whether that flag drives an interrupt request. A capture strobe copies the current count into a capture register.

Software reaches all 24-bit quantities through a single byte-wide window. A 2-bit byte index picks the byte, and a 3-bit select code picks what the window shows. Multi-byte reads stay coherent because reading the live low byte freezes the two upper bytes. Multi-byte writes are atomic: the low and middle bytes wait in shadow registers, and the whole value is applied only when the high byte is written.

Top module: `ovf_count_window`

## Requirements
- R1: After reset the count, period, both compare values, capture register and all three flags are 0, and every interrupt request is low.
- R2: A read of byte 0 with select 000 returns the live low byte. In the same access it latches count bits 23:8, and later reads of bytes 1 and 2 with select 000 return that latched copy even if the count has since moved.
- R3: With a writable select, writes to bytes 0 and 1 only fill shadow registers and leave the target unchanged. A write to byte 2 loads {byte 2 data, byte 1 shadow, byte 0 shadow} into the target on that clock edge.
- R4: The count increments by one only on a cycle where the wrap strobe is high and holds otherwise. A committing high-byte write to the count in the same cycle as a wrap takes priority, and the written value is loaded without an increment.
- R5: When an increment would make the count equal the period, the count becomes 0 instead and the period event (flag bit 0) fires. With period 0 this happens at the 24-bit rollover.
- R6: When an increment makes the count equal compare value 1 or compare value 2, the matching event fires: flag bit 1 for compare value 1 and flag bit 2 for compare value 2. The value tested is the incremented one, before any period clear.
- R7: A flag is set by its event whatever its mask. Each interrupt request bit equals its flag bit ANDed with its mask bit.
- R8: A flag write clears each flag whose written bit is 0 and leaves flags whose written bit is 1 unchanged. An event in the same cycle as a clear leaves that flag set.
- R9: A capture strobe copies the current count into the capture register, which reads back with select 001.
- R10: The select codes are 000 live count, 001 capture (read-only), 010 period, 011 compare value 1 and 100 compare value 2. Writes with 001 or with codes 101 to 111 change nothing. Those unused codes, and byte index 3 with any code, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrapStb | input | 1 | Base timer wrap strobe, one per increment |
| captureStb | input | 1 | Capture the current count |
| winSel | input | 3 | Window select code |
| byteIdx | input | 2 | Byte index in the window (0 low, 2 high) |
| wrEn | input | 1 | Window write strobe |
| wrData | input | 8 | Window write data |
| rdEn | input | 1 | Window read strobe (drives the upper-byte latch) |
| rdData | output | 8 | Window read data, combinational |
| flagWrEn | input | 1 | Flag write strobe |
| flagWrData | input | 3 | Flag write data, a 0 bit clears that flag |
| irqMask | input | 3 | Per-event interrupt mask |
| flags | output | 3 | Sticky event flags: bit 0 period, bit 1 compare 1, bit 2 compare 2 |
| irqReq | output | 3 | Masked interrupt requests |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the same cycle as a new event for that flag. The bench loads the count through the window so that the next wrap hits compare value 1. It then raises the wrap strobe and a clearing flag write on the same negative edge, and checks that the flag is still set. Latch coherence needs a count whose middle and high bytes change between the low-byte read and the upper-byte reads. The bench therefore starts the count just below a middle-byte carry and applies wraps between the reads.

// File: rtl/ovc_pkg.sv
package ovc_pkg;

  localparam int NUM_EV  = 3;
  localparam int EV_PER  = 0;
  localparam int EV_CMP1 = 1;
  localparam int EV_CMP2 = 2;
  localparam int NUM_CMP = 2;

  typedef enum logic [2:0] {
    SEL_LIVE   = 3'd0,
    SEL_CAPT   = 3'd1,
    SEL_PERIOD = 3'd2,
    SEL_CMP1   = 3'd3,
    SEL_CMP2   = 3'd4
  } winSel_e;

  typedef struct packed {
    logic               shadowWr;
    logic               commitCnt;
    logic               commitPer;
    logic [NUM_CMP-1:0] commitCmp;
    logic               latchHi;
  } ctrlStrobes_t;

endpackage

// File: rtl/ovc_ctrl.sv
module ovc_ctrl
  import ovc_pkg::*;
#(
  parameter int NUM_BYTES = 3,
  parameter int SEL_W     = 3,
  parameter int IDX_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  winSel,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [NUM_EV-1:0] evVec,
  input  logic              flagWrEn,
  input  logic [NUM_EV-1:0] flagWrData,
  input  logic [NUM_EV-1:0] irqMask,
  output ctrlStrobes_t      strobes,
  output logic [NUM_EV-1:0] flags,
  output logic [NUM_EV-1:0] irqReq
);

  localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(NUM_BYTES - 1);

  logic              writable;
  logic              hiWrite;
  logic [NUM_EV-1:0] clrMask;
  logic [NUM_EV-1:0] flagsQ;

  always_comb begin
    writable = (winSel == SEL_LIVE) || (winSel == SEL_PERIOD) ||
               (winSel == SEL_CMP1) || (winSel == SEL_CMP2);
    hiWrite  = wrEn && writable && (byteIdx == HI_IDX);

    strobes.shadowWr     = wrEn && writable && (byteIdx < HI_IDX);
    strobes.commitCnt    = hiWrite && (winSel == SEL_LIVE);
    strobes.commitPer    = hiWrite && (winSel == SEL_PERIOD);
    strobes.commitCmp[0] = hiWrite && (winSel == SEL_CMP1);
    strobes.commitCmp[1] = hiWrite && (winSel == SEL_CMP2);
    strobes.latchHi      = rdEn && (winSel == SEL_LIVE) && (byteIdx == '0);
  end

  // A 0 in a written flag bit clears it; events override the clear.
  assign clrMask = flagWrEn ? ~flagWrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= (flagsQ & ~clrMask) | evVec;
  end

  assign flags  = flagsQ;
  assign irqReq = flagsQ & irqMask;

  AST_FLAG_ON_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (|evVec) |=> ((flagsQ & $past(evVec)) == $past(evVec))); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !flagWrEn |=> ((flagsQ & $past(flagsQ)) == $past(flagsQ))); // R8

endmodule

// File: rtl/ovc_datapath.sv
module ovc_datapath
  import ovc_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int SEL_W     = 3,
  parameter int IDX_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [SEL_W-1:0]  winSel,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrapStb,
  input  logic              captureStb,
  output logic [BYTE_W-1:0] rdData,
  output logic [NUM_EV-1:0] evVec
);

  localparam int CNT_W = BYTE_W * NUM_BYTES;
  localparam int HI_W  = CNT_W - BYTE_W;
  localparam int NSH   = NUM_BYTES - 1;

  logic [BYTE_W-1:0] shadowQ [NSH];
  logic [CNT_W-1:0]  commitVal;
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  perQ;
  logic [CNT_W-1:0]  capQ;
  logic [CNT_W-1:0]  cmpQ [NUM_CMP];
  logic [HI_W-1:0]   latchQ;
  logic [CNT_W-1:0]  nextCnt;
  logic              incEn;
  logic              evPer;
  logic [NUM_CMP-1:0] evCmp;
  logic [CNT_W-1:0]  winSrc;

  // Shadow bytes for the lower part of an atomic write
  for (genvar s = 0; s < NSH; s++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rstN)
        shadowQ[s] <= '0;
      else if (strobes.shadowWr && (byteIdx == IDX_W'(s)))
        shadowQ[s] <= wrData;
    end
  end

  always_comb begin
    commitVal = '0;
    for (int b = 0; b < NSH; b++) commitVal[b*BYTE_W +: BYTE_W] = shadowQ[b];
    commitVal[CNT_W-1 -: BYTE_W] = wrData;
  end

  // Counter and event detection
  assign incEn   = wrapStb && !strobes.commitCnt;
  assign nextCnt = cntQ + CNT_W'(1);
  assign evPer   = incEn && (nextCnt == perQ);

  always_ff @(posedge clk) begin
    if (!rstN)                  cntQ <= '0;
    else if (strobes.commitCnt) cntQ <= commitVal;
    else if (evPer)             cntQ <= '0;
    else if (incEn)             cntQ <= nextCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  perQ <= '0;
    else if (strobes.commitPer) perQ <= commitVal;
  end

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rstN)                     cmpQ[c] <= '0;
      else if (strobes.commitCmp[c]) cmpQ[c] <= commitVal;
    end
    assign evCmp[c] = incEn && (nextCnt == cmpQ[c]);
  end

  always_comb begin
    evVec          = '0;
    evVec[EV_PER]  = evPer;
    evVec[EV_CMP1] = evCmp[0];
    evVec[EV_CMP2] = evCmp[1];
  end

  // Capture and coherent-read latch
  always_ff @(posedge clk) begin
    if (!rstN)           capQ <= '0;
    else if (captureStb) capQ <= cntQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                latchQ <= '0;
    else if (strobes.latchHi) latchQ <= cntQ[CNT_W-1:BYTE_W];
  end

  // Read window
  always_comb begin
    case (winSel)
      SEL_LIVE:   winSrc = {latchQ, cntQ[BYTE_W-1:0]};
      SEL_CAPT:   winSrc = capQ;
      SEL_PERIOD: winSrc = perQ;
      SEL_CMP1:   winSrc = cmpQ[0];
      SEL_CMP2:   winSrc = cmpQ[1];
      default:    winSrc = '0;
    endcase
    rdData = '0;
    for (int i = 0; i < NUM_BYTES; i++)
      if (byteIdx == IDX_W'(i)) rdData = winSrc[i*BYTE_W +: BYTE_W];
  end

  AST_PERIOD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    evPer |=> (cntQ == '0)); // R5

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!wrapStb && !strobes.commitCnt) |=> $stable(cntQ)); // R4

  AST_COMMIT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitCnt |=> (cntQ[CNT_W-1 -: BYTE_W] == $past(wrData))); // R3

  AST_LATCH_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchHi |=> (latchQ == $past(cntQ[CNT_W-1:BYTE_W]))); // R2

endmodule

// File: rtl/ovf_count_window.sv
module ovf_count_window
  import ovc_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int SEL_W     = 3,
  parameter int IDX_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrapStb,
  input  logic              captureStb,
  input  logic [SEL_W-1:0]  winSel,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  output logic [BYTE_W-1:0] rdData,
  input  logic              flagWrEn,
  input  logic [NUM_EV-1:0] flagWrData,
  input  logic [NUM_EV-1:0] irqMask,
  output logic [NUM_EV-1:0] flags,
  output logic [NUM_EV-1:0] irqReq
);

  ctrlStrobes_t      strobes;
  logic [NUM_EV-1:0] evVec;

  ovc_ctrl #(
    .NUM_BYTES(NUM_BYTES), .SEL_W(SEL_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .winSel(winSel), .byteIdx(byteIdx),
    .wrEn(wrEn), .rdEn(rdEn), .evVec(evVec),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData), .irqMask(irqMask),
    .strobes(strobes), .flags(flags), .irqReq(irqReq)
  );

  ovc_datapath #(
    .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .SEL_W(SEL_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .winSel(winSel),
    .byteIdx(byteIdx), .wrData(wrData), .wrapStb(wrapStb),
    .captureStb(captureStb), .rdData(rdData), .evVec(evVec)
  );

endmodule

// File: tb/tb_ovf_count_window.sv
`timescale 1ns/1ps
module tb_ovf_count_window;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrapStb = 1'b0;
  logic       captureStb = 1'b0;
  logic [2:0] winSel = 3'd0;
  logic [1:0] byteIdx = 2'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       flagWrEn = 1'b0;
  logic [2:0] flagWrData = 3'b111;
  logic [2:0] irqMask = 3'b000;
  logic [2:0] flags;
  logic [2:0] irqReq;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  ovf_count_window dut (
    .clk(clk), .rstN(rstN), .wrapStb(wrapStb), .captureStb(captureStb),
    .winSel(winSel), .byteIdx(byteIdx), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .flagWrEn(flagWrEn),
    .flagWrData(flagWrData), .irqMask(irqMask), .flags(flags),
    .irqReq(irqReq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [2:0] sel, logic [1:0] idx, logic [7:0] d);
    @(negedge clk);
    winSel = sel; byteIdx = idx; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic write24(logic [2:0] sel, logic [23:0] v);
    busWrite(sel, 2'd0, v[7:0]);
    busWrite(sel, 2'd1, v[15:8]);
    busWrite(sel, 2'd2, v[23:16]);
  endtask

  task automatic busRead(logic [2:0] sel, logic [1:0] idx, output logic [7:0] d);
    @(negedge clk);
    winSel = sel; byteIdx = idx; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic read24(logic [2:0] sel, output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    busRead(sel, 2'd0, b0);
    busRead(sel, 2'd1, b1);
    busRead(sel, 2'd2, b2);
    v = {b2, b1, b0};
  endtask

  task automatic wraps(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wrapStb = 1'b1;
      @(negedge clk); wrapStb = 1'b0;
    end
  endtask

  task automatic clearFlags(logic [2:0] keep);
    @(negedge clk); flagWrEn = 1'b1; flagWrData = keep;
    @(negedge clk); flagWrEn = 1'b0; flagWrData = 3'b111;
  endtask

  task automatic testReset();
    logic [23:0] v;
    read24(3'd0, v); check("R1 count", v, 0);
    read24(3'd2, v); check("R1 period", v, 0);
    read24(3'd3, v); check("R1 cmp1", v, 0);
    read24(3'd1, v); check("R1 capture", v, 0);
    check("R1 flags", flags, 0);
    check("R1 irq", irqReq, 0);
  endtask

  task automatic testAtomicWrite();
    logic [23:0] v;
    write24(3'd0, 24'h000010);
    busWrite(3'd0, 2'd0, 8'h34);
    busWrite(3'd0, 2'd1, 8'h12);
    read24(3'd0, v); check("R3 before high byte", v, 24'h000010);
    busWrite(3'd0, 2'd2, 8'h56);
    read24(3'd0, v); check("R3 after high byte", v, 24'h561234);
  endtask

  task automatic testIncrement();
    logic [23:0] v;
    write24(3'd0, 24'h000100);
    wraps(5);
    read24(3'd0, v); check("R4 five wraps", v, 24'h000105);
    repeat (6) @(negedge clk);
    read24(3'd0, v); check("R4 hold without wrap", v, 24'h000105);
  endtask

  task automatic testReadLatch();
    logic [7:0] b;
    write24(3'd0, 24'h01FFFE);
    busRead(3'd0, 2'd0, b); check("R2 live low", b, 8'hFE);
    wraps(3);
    busRead(3'd0, 2'd1, b); check("R2 latched mid", b, 8'hFF);
    busRead(3'd0, 2'd2, b); check("R2 latched high", b, 8'h01);
    busRead(3'd0, 2'd0, b); check("R2 live low moved", b, 8'h01);
    busRead(3'd0, 2'd1, b); check("R2 relatched mid", b, 8'h00);
    busRead(3'd0, 2'd2, b); check("R2 relatched high", b, 8'h02);
  endtask

  task automatic testPeriod();
    logic [23:0] v;
    irqMask = 3'b000;
    write24(3'd2, 24'd10);
    write24(3'd0, 24'd7);
    wraps(2);
    check("R5 no event before period", flags[0], 0);
    wraps(1);
    check("R5 period flag", flags[0], 1);
    check("R7 masked irq low", irqReq[0], 0);
    read24(3'd0, v); check("R5 count cleared", v, 0);
    irqMask = 3'b001;
    #1 check("R7 irq with mask", irqReq[0], 1);
    irqMask = 3'b000;
    write24(3'd2, 24'd0);
    clearFlags(3'b000);
    check("R8 flags cleared", flags, 0);
  endtask

  task automatic testCompare();
    logic [23:0] v;
    write24(3'd3, 24'd3);
    write24(3'd4, 24'd5);
    read24(3'd3, v); check("R10 cmp1 readback", v, 24'd3);
    read24(3'd4, v); check("R10 cmp2 readback", v, 24'd5);
    write24(3'd0, 24'd0);
    wraps(3);
    check("R6 cmp1 flag", flags, 3'b010);
    wraps(2);
    check("R6 cmp2 flag", flags, 3'b110);
    irqMask = 3'b100;
    #1 check("R7 only cmp2 irq", irqReq, 3'b100);
    irqMask = 3'b000;
    clearFlags(3'b010);
    check("R8 selective clear", flags, 3'b010);
  endtask

  task automatic testClearVsEvent();
    write24(3'd0, 24'd2);
    @(negedge clk);
    wrapStb = 1'b1; flagWrEn = 1'b1; flagWrData = 3'b000;
    @(negedge clk);
    wrapStb = 1'b0; flagWrEn = 1'b0; flagWrData = 3'b111;
    check("R8 event beats clear", flags, 3'b010);
    clearFlags(3'b000);
  endtask

  task automatic testCommitPriority();
    logic [23:0] v;
    write24(3'd0, 24'h000050);
    busWrite(3'd0, 2'd0, 8'h20);
    busWrite(3'd0, 2'd1, 8'h00);
    @(negedge clk);
    winSel = 3'd0; byteIdx = 2'd2; wrData = 8'h00; wrEn = 1'b1; wrapStb = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrapStb = 1'b0;
    read24(3'd0, v); check("R4 commit beats wrap", v, 24'h000020);
  endtask

  task automatic testCaptureAndSelect();
    logic [23:0] v;
    logic [7:0]  b;
    write24(3'd0, 24'hABCDEF);
    @(negedge clk); captureStb = 1'b1;
    @(negedge clk); captureStb = 1'b0;
    wraps(2);
    read24(3'd1, v); check("R9 captured count", v, 24'hABCDEF);
    write24(3'd1, 24'h111111);
    read24(3'd1, v); check("R10 capture read-only", v, 24'hABCDEF);
    write24(3'd5, 24'h222222);
    read24(3'd0, v); check("R10 unused code write ignored", v, 24'hABCDF1);
    busRead(3'd5, 2'd0, b); check("R10 unused code reads 0", b, 0);
    busRead(3'd3, 2'd3, b); check("R10 byte 3 reads 0", b, 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testAtomicWrite();
    testIncrement();
    testReadLatch();
    testPeriod();
    testCompare();
    testClearVsEvent();
    testCommitPriority();
    testCaptureAndSelect();
    finish();
  end

endmodule